// File: doc/BRIEF.md
# Gate Driver Desaturation Fault Controller

This block is the digital control core of an isolated power-switch gate driver. A controller supplies a complementary pair of command inputs; the block turns them into enables for a strong pull-up, a strong pull-down, a weak soft-shutdown pull-down and a Miller clamp. Analog sensing is supplied as digital flags: a desaturation comparator output, a "gate voltage below 2 V" comparator output and a driver-side undervoltage flag.

After each turn-on, the block masks the desaturation flag for a programmable number of cycles. This mimics the charging of a blanking capacitor. A desaturation seen after that window latches a fault and drops the active-low fault output. The gate is then discharged through the weak path only, until the gate-low flag reports that the switch is off. From then on, the strong pull-down holds the gate. The fault ignores all command activity until the controller pulls the clear input low. After a clear, the drive stays off until a fresh off-to-on command edge. Undervoltage overrides everything and forces the strong pull-down.

Top module: `gdrv_fault_ctrl`

## Requirements
- R1: The command is on only when `in_pos`=1 and `in_neg`=0. A command sampled on at a clock edge from the off state raises `pu_en` after that edge. Any other input pair keeps `pu_en`=0 and `pd_en`=1.
- R2: During the first `blank_cycles` clock edges after the turn-on edge, a high `desat` is ignored. The drive stays on and `fault_n` stays 1.
- R3: The first edge after the blanking window at which `desat`=1 starts a fault. From the next cycle, `pu_en`=0, `pd_en`=0, `ss_en`=1 and `fault_n`=0.
- R4: Soft shutdown (`ss_en`=1) lasts until an edge samples `gate_low`=1. After that edge, `ss_en`=0 and `pd_en`=1, and the strong pull-down stays held while the fault is latched.
- R5: `fault_n` stays 0 until `fault_clr_n`=0 is sampled after soft shutdown has completed. A low `fault_clr_n` during soft shutdown is ignored.
- R6: While a fault is latched, changes on `in_pos`/`in_neg` do not change any output.
- R7: `clamp_en`=1 exactly when `gate_low`=1 and the strong pull-down is the only active driver (`pd_en`=1, `pu_en`=0, `ss_en`=0).
- R8: `uvlo`=1 forces `pd_en`=1, `pu_en`=0 and `ss_en`=0 in the same cycle. It cancels an active drive, and drive resumes only after a fresh off-to-on command edge.
- R9: The blanking count reloads on every off-to-on edge and is cleared when the command goes off. A re-turn-on always gets the full window.
- R10: At most one of `pu_en`, `pd_en` and `ss_en` is 1 in any cycle.
- R11: After a fault is cleared while the command is on, `pu_en` stays 0 and `fault_n` is 1 until the command is seen off and then on again.
- R12: A synchronous `rst`=1 gives `pd_en`=1, `pu_en`=0, `ss_en`=0 and `fault_n`=1. After reset, drive needs the command to be seen off before a turn-on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_pos | input | 1 | Non-inverting command input |
| in_neg | input | 1 | Inverting command input |
| desat | input | 1 | Desaturation comparator flag |
| gate_low | input | 1 | Gate voltage below 2 V flag |
| fault_clr_n | input | 1 | Active-low fault clear, sampled synchronously |
| uvlo | input | 1 | Driver-side undervoltage flag |
| blank_cycles | input | BLANK_W | Blanking window length in clock cycles |
| pu_en | output | 1 | Strong pull-up enable |
| pd_en | output | 1 | Strong pull-down enable |
| ss_en | output | 1 | Weak soft-shutdown pull-down enable |
| clamp_en | output | 1 | Miller clamp enable |
| fault_n | output | 1 | Active-low fault indication |

## Verification
Some properties hold in every cycle, and the assertions check these continuously:
- the three drivers are mutually exclusive;
- undervoltage overrides the drive;
- the clamp engages only under the strong pull-down with the gate low;
- the fault holds while the clear input is high;
- there is no pull-up while faulted or just after a clear.

Other behaviours depend on the history of the inputs, and only the bench scenarios can show them: the exact length of the blanking window and its restart after a short pulse, deferral of a clear issued during soft shutdown, and the need for a fresh command edge after a clear, a reset or an undervoltage event. The bench compares every output against a behavioural model on every cycle.

// File: rtl/gdrv_pkg.sv
package gdrv_pkg;

    typedef enum logic [2:0] {
        ST_REARM = 3'd0,
        ST_OFF   = 3'd1,
        ST_ON    = 3'd2,
        ST_SOFT  = 3'd3,
        ST_HOLD  = 3'd4
    } drv_state_e;

    typedef struct packed {
        logic pull_up;
        logic pull_dn;
        logic soft_dn;
        logic clamp;
    } drv_en_t;

    function automatic logic cmd_on(input logic pos, input logic neg);
        return pos & ~neg;
    endfunction

    function automatic logic is_faulted(input drv_state_e s);
        return (s == ST_SOFT) || (s == ST_HOLD);
    endfunction

endpackage

// File: rtl/gdrv_blank_timer.sv
module gdrv_blank_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         run,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] ZERO = '0;

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= ZERO;
        end else if (load) begin
            cnt <= load_val;
        end else if (!run) begin
            cnt <= ZERO;
        end else if (cnt != ZERO) begin
            cnt <= cnt - ONE;
        end
    end

    assign expired = (cnt == ZERO);
endmodule

// File: rtl/gdrv_fault_fsm.sv
module gdrv_fault_fsm
    import gdrv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd,
    input  logic       desat,
    input  logic       gate_low,
    input  logic       clr_n,
    input  logic       uvlo,
    input  logic       blank_done,
    output drv_state_e state,
    output logic       load_blank,
    output logic       run_blank
);
    drv_state_e nxt;

    always_comb begin
        nxt = state;
        case (state)
            ST_SOFT: if (gate_low) nxt = ST_HOLD;
            ST_HOLD: if (!clr_n) nxt = ST_REARM;
            ST_REARM: begin
                if (!cmd) nxt = ST_OFF;
            end
            ST_OFF: begin
                if (cmd && !uvlo) nxt = ST_ON;
            end
            ST_ON: begin
                if (uvlo)                   nxt = ST_REARM;
                else if (!cmd)              nxt = ST_OFF;
                else if (blank_done && desat) nxt = ST_SOFT;
            end
            default: nxt = ST_REARM;
        endcase
        if (uvlo && !is_faulted(state)) begin
            nxt = cmd ? ST_REARM : ST_OFF;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_REARM;
        else     state <= nxt;
    end

    assign load_blank = (state == ST_OFF) && cmd && !uvlo;
    assign run_blank  = (state == ST_ON);
endmodule

// File: rtl/gdrv_out_map.sv
module gdrv_out_map
    import gdrv_pkg::*;
(
    input  drv_state_e state,
    input  logic       uvlo,
    input  logic       gate_low,
    output drv_en_t    en,
    output logic       fault_n
);
    always_comb begin
        en = '0;
        if (uvlo) begin
            en.pull_dn = 1'b1;
        end else begin
            case (state)
                ST_ON:   en.pull_up = 1'b1;
                ST_SOFT: en.soft_dn = 1'b1;
                default: en.pull_dn = 1'b1;
            endcase
        end
        en.clamp = gate_low && en.pull_dn && !en.pull_up && !en.soft_dn;
    end

    assign fault_n = !is_faulted(state);
endmodule

// File: rtl/gdrv_fault_ctrl.sv
module gdrv_fault_ctrl
    import gdrv_pkg::*;
#(
    parameter int BLANK_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_pos,
    input  logic               in_neg,
    input  logic               desat,
    input  logic               gate_low,
    input  logic               fault_clr_n,
    input  logic               uvlo,
    input  logic [BLANK_W-1:0] blank_cycles,
    output logic               pu_en,
    output logic               pd_en,
    output logic               ss_en,
    output logic               clamp_en,
    output logic               fault_n
);
    logic       cmd;
    logic       load_blank;
    logic       run_blank;
    logic       blank_done;
    drv_state_e state;
    drv_en_t    en;

    assign cmd = cmd_on(in_pos, in_neg);

    gdrv_blank_timer #(.W(BLANK_W)) u_blank (
        .clk      (clk),
        .rst      (rst),
        .load     (load_blank),
        .run      (run_blank),
        .load_val (blank_cycles),
        .expired  (blank_done)
    );

    gdrv_fault_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .cmd        (cmd),
        .desat      (desat),
        .gate_low   (gate_low),
        .clr_n      (fault_clr_n),
        .uvlo       (uvlo),
        .blank_done (blank_done),
        .state      (state),
        .load_blank (load_blank),
        .run_blank  (run_blank)
    );

    gdrv_out_map u_map (
        .state    (state),
        .uvlo     (uvlo),
        .gate_low (gate_low),
        .en       (en),
        .fault_n  (fault_n)
    );

    assign pu_en    = en.pull_up;
    assign pd_en    = en.pull_dn;
    assign ss_en    = en.soft_dn;
    assign clamp_en = en.clamp;
endmodule

// File: rtl/gdrv_fault_ctrl_chk.sv
module gdrv_fault_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic gate_low,
    input logic fault_clr_n,
    input logic uvlo,
    input logic pu_en,
    input logic pd_en,
    input logic ss_en,
    input logic clamp_en,
    input logic fault_n
);
    assert_excl_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pu_en, pd_en, ss_en}));

    assert_uvlo_R8: assert property (@(posedge clk) disable iff (rst)
        uvlo |-> (pd_en && !pu_en && !ss_en));

    assert_clamp_R7: assert property (@(posedge clk) disable iff (rst)
        clamp_en |-> (gate_low && pd_en && !pu_en && !ss_en));

    assert_latch_R5: assert property (@(posedge clk) disable iff (rst)
        (!fault_n && fault_clr_n) |=> !fault_n);

    assert_nodrive_R6: assert property (@(posedge clk) disable iff (rst)
        !fault_n |-> !pu_en);

    assert_softhold_R4: assert property (@(posedge clk) disable iff (rst)
        (ss_en && !gate_low) |=> (!fault_n && !pu_en));

    assert_rearm_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_n) |-> !pu_en);
endmodule

bind gdrv_fault_ctrl gdrv_fault_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .gate_low    (gate_low),
    .fault_clr_n (fault_clr_n),
    .uvlo        (uvlo),
    .pu_en       (pu_en),
    .pd_en       (pd_en),
    .ss_en       (ss_en),
    .clamp_en    (clamp_en),
    .fault_n     (fault_n)
);

// File: tb/gdrv_fault_ctrl_bench.sv
module gdrv_fault_ctrl_bench;
    localparam int BW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_pos = 1'b0, in_neg = 1'b0, desat = 1'b0, gate_low = 1'b0;
    logic fault_clr_n = 1'b1, uvlo = 1'b0;
    logic [BW-1:0] blank_cycles = 8'd4;
    logic pu_en, pd_en, ss_en, clamp_en, fault_n;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    // behavioural reference state
    bit m_fault = 0, m_soft = 0, m_need_low = 1, m_on = 0;
    int m_blank = 0;

    always #10 clk = ~clk;

    gdrv_fault_ctrl #(.BLANK_W(BW)) u_gdrv_fault_ctrl (
        .clk(clk), .rst(rst), .in_pos(in_pos), .in_neg(in_neg),
        .desat(desat), .gate_low(gate_low), .fault_clr_n(fault_clr_n),
        .uvlo(uvlo), .blank_cycles(blank_cycles),
        .pu_en(pu_en), .pd_en(pd_en), .ss_en(ss_en),
        .clamp_en(clamp_en), .fault_n(fault_n)
    );

    always @(posedge clk) begin
        bit c;
        c = in_pos && !in_neg;
        cycles <= cycles + 1;
        if (rst) begin
            m_fault <= 0; m_soft <= 0; m_need_low <= 1; m_on <= 0; m_blank <= 0;
        end else if (m_soft) begin
            if (gate_low) m_soft <= 0;
        end else if (m_fault) begin
            if (!fault_clr_n) begin m_fault <= 0; m_need_low <= 1; end
        end else if (uvlo) begin
            m_on <= 0; m_need_low <= c; m_blank <= 0;
        end else if (m_need_low) begin
            if (!c) m_need_low <= 0;
        end else if (!m_on) begin
            if (c) begin m_on <= 1; m_blank <= int'(blank_cycles); end
        end else if (!c) begin
            m_on <= 0; m_blank <= 0;
        end else if (m_blank > 0) begin
            m_blank <= m_blank - 1;
        end else if (desat) begin
            m_on <= 0; m_soft <= 1; m_fault <= 1;
        end
    end

    task automatic cmp(input string tag, input string sig, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, sig, act, exp, $time);
        end
    endtask

    task automatic check_all(input string tag);
        logic e_pu, e_pd, e_ss, e_cl;
        e_pu = 0; e_pd = 0; e_ss = 0;
        if (uvlo)        e_pd = 1;
        else if (m_soft) e_ss = 1;
        else if (m_on)   e_pu = 1;
        else             e_pd = 1;
        e_cl = gate_low && e_pd;
        cmp(tag, "pu_en", pu_en, e_pu);
        cmp(tag, "pd_en", pd_en, e_pd);
        cmp(tag, "ss_en", ss_en, e_ss);
        cmp(tag, "clamp_en", clamp_en, e_cl);
        cmp(tag, "fault_n", fault_n, !m_fault);
        cmp("R10", "pu_and_pd", pu_en && pd_en, 1'b0);
    endtask

    task automatic step(input string tag, input logic p, input logic n, input logic d,
                        input logic g, input logic c, input logic u);
        @(negedge clk);
        in_pos = p; in_neg = n; desat = d; gate_low = g; fault_clr_n = c; uvlo = u;
        #2;
        check_all(tag);
    endtask

    initial begin
        // R12 reset state
        rst = 1'b1;
        repeat (3) step("R12", 1, 0, 0, 0, 1, 0);
        @(negedge clk); rst = 1'b0;
        // R12 command already on after reset: no drive
        repeat (3) step("R12", 1, 0, 0, 0, 1, 0);
        // R1 decode
        step("R1", 0, 0, 0, 0, 1, 0);
        step("R1", 1, 1, 0, 0, 1, 0);
        step("R1", 0, 1, 0, 0, 1, 0);
        step("R1", 1, 0, 0, 0, 1, 0);
        step("R1", 1, 0, 0, 0, 1, 0);
        step("R1", 1, 1, 0, 0, 1, 0);
        step("R7", 0, 0, 0, 1, 1, 0);
        // R2 desat inside blanking ignored, R3 after
        step("R2", 1, 0, 0, 0, 1, 0);
        repeat (4) step("R2", 1, 0, 1, 0, 1, 0);
        step("R3", 1, 0, 1, 0, 1, 0);
        step("R3", 1, 0, 0, 0, 1, 0);
        // soft shutdown: clear ignored, command toggling ignored
        step("R5", 0, 0, 0, 0, 0, 0);
        step("R6", 1, 0, 0, 0, 1, 0);
        step("R6", 0, 1, 0, 0, 1, 0);
        step("R4", 1, 0, 0, 1, 1, 0);
        step("R4", 1, 0, 0, 1, 1, 0);
        step("R7", 0, 0, 0, 1, 1, 0);
        step("R6", 1, 0, 1, 0, 1, 0);
        step("R6", 1, 0, 0, 0, 1, 0);
        // clear with command on
        step("R11", 1, 0, 0, 0, 0, 0);
        repeat (3) step("R11", 1, 0, 0, 0, 1, 0);
        step("R11", 0, 0, 0, 0, 1, 0);
        step("R11", 1, 0, 0, 0, 1, 0);
        step("R11", 1, 0, 0, 0, 1, 0);
        // R9 blanking restart: turn off mid window, re-on, desat in new window
        step("R9", 1, 0, 0, 0, 1, 0);
        step("R9", 0, 0, 0, 0, 1, 0);
        step("R9", 1, 0, 0, 0, 1, 0);
        repeat (3) step("R9", 1, 0, 1, 0, 1, 0);
        step("R9", 0, 0, 0, 0, 1, 0);
        step("R9", 1, 0, 0, 0, 1, 0);
        repeat (6) step("R9", 1, 0, 1, 0, 1, 0);
        step("R4", 1, 0, 0, 1, 1, 0);
        step("R5", 1, 0, 0, 0, 0, 0);
        step("R5", 0, 0, 0, 0, 1, 0);
        // R8 undervoltage during drive
        step("R8", 1, 0, 0, 0, 1, 0);
        step("R8", 1, 0, 0, 0, 1, 0);
        step("R8", 1, 0, 0, 1, 1, 1);
        step("R8", 1, 0, 0, 0, 1, 0);
        step("R8", 1, 0, 0, 0, 1, 0);
        step("R8", 0, 0, 0, 0, 1, 0);
        step("R8", 1, 0, 0, 0, 1, 0);
        step("R8", 1, 0, 0, 0, 1, 0);
        // undervoltage during soft shutdown
        blank_cycles = 8'd0;
        step("R3", 1, 0, 1, 0, 1, 0);
        step("R8", 1, 0, 0, 0, 1, 1);
        step("R8", 1, 0, 0, 0, 1, 0);
        step("R4", 0, 0, 0, 1, 1, 0);
        step("R5", 0, 0, 0, 0, 0, 0);
        step("R2", 1, 0, 0, 0, 1, 0);
        step("R2", 1, 0, 0, 0, 1, 0);
        step("R3", 1, 0, 1, 0, 1, 0);
        step("R3", 0, 0, 0, 0, 1, 0);
        repeat (2) step("R1", 0, 0, 0, 0, 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cycles > 100000);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected<=100000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule